// File: doc/BRIEF.md
# Dual-path output cell with DDR, latch and bypass modes

This block sits between core logic and an output pad. It carries two independent paths: a data path that produces the value driven onto the pin, and a tristate path that produces the pad's enable control. Each path has its own mode, chosen from four: a rising-edge register, double data rate, a level-sensitive latch, or a direct combinational bypass. In double data rate mode each path can align its two inputs in one of two ways. The opposite-edge option samples the first input on the rising edge and the second on the falling edge. The same-edge option samples both inputs on the rising edge and delays the second by half a cycle.

There is a single clock. The falling-edge stage runs from the inverted clock, and in double data rate mode the clock level itself selects which stored value reaches the output. No separate select input exists. Both paths share a synchronous clear and a synchronous preset, and each path has its own clock enable. The mode inputs are static straps, set while the block is in use.

Top module: `dual_path_out_cell`

## Requirements
- R1: While `rst_n` is low at a clock edge, all registered and latched state is cleared to zero. Once reset ends, with a path in register mode (mode code 2'b00), that path's output reads zero until new data is captured.
- R2: In register mode (code 2'b00), the output shows the first data input as sampled at the last rising edge with the enable high. It is stable over both clock phases.
- R3: In bypass mode (code 2'b11), the output equals the first data input at all times, including changes made during the low phase.
- R4: In latch mode (code 2'b10), the output follows the first data input while the clock is high. It holds the last value seen during the high phase while the clock is low, ignoring changes made in that phase.
- R5: In double data rate mode (code 2'b01) with the alignment bit at 0 (opposite-edge), the first input is sampled on the rising edge and shown while the clock is high. The second input is sampled on the falling edge and shown while the clock is low.
- R6: In double data rate mode with the alignment bit at 1 (same-edge), both inputs are sampled on the rising edge. The second input's value from that edge is shown in the following low phase, and a change to it after the rising edge does not reach the output.
- R7: A high `sr` at a rising edge clears the stored value to all zeros, and a high `rev` sets it to all ones. When both are high, `sr` wins.
- R8: With a path's enable low and neither `sr` nor `rev` asserted, that path's stored values hold and its registered output does not change.
- R9: The tristate path uses the same mode codes and alignment bit as the data path. It is configured and enabled independently, so a held or differently moded tristate path does not affect the data path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock; its level selects the DDR output phase |
| rst_n | input | 1 | Synchronous active-low reset |
| sr | input | 1 | Synchronous clear of stored values (wins over rev) |
| rev | input | 1 | Synchronous preset of stored values to all ones |
| dat_mode | input | 2 | Data path mode: 00 register, 01 DDR, 10 latch, 11 bypass |
| dat_same_edge | input | 1 | Data path DDR alignment: 0 opposite-edge, 1 same-edge |
| dat_a | input | WIDTH | Data path first input (rising-edge / high-phase value) |
| dat_b | input | WIDTH | Data path second input (low-phase value in DDR) |
| dat_ce | input | 1 | Data path clock enable |
| ts_mode | input | 2 | Tristate path mode, same codes as dat_mode |
| ts_same_edge | input | 1 | Tristate path DDR alignment |
| ts_a | input | TS_WIDTH | Tristate path first input |
| ts_b | input | TS_WIDTH | Tristate path second input |
| ts_ce | input | 1 | Tristate path clock enable |
| dat_q | output | WIDTH | Value for the pad driver |
| ts_q | output | TS_WIDTH | Enable control for the pad driver |

## Verification
The hardest case to reach from the ports is the one that separates the two DDR alignments. In the ordinary case both show the first input in the high phase and the second in the low phase. The difference appears only when the second input changes between a rising edge and the next falling edge. The stimulus therefore changes that input one nanosecond after the rising edge and samples the low phase for each alignment. The latch hold and the bypass pass-through are reached the same way, by changing the first input in the middle of a phase instead of only before an edge.

// File: rtl/dpo_pkg.sv
// Package: shared mode encoding for the dual-path output cell.
// Assumes the mode inputs are static while the cell is in use.
package dpo_pkg;
    typedef enum logic [1:0] {
        MODE_REG   = 2'b00,
        MODE_DDR   = 2'b01,
        MODE_LATCH = 2'b10,
        MODE_BYP   = 2'b11
    } path_mode_e;
endpackage

// File: rtl/dpo_rise_stage.sv
// Rising-edge stage: captures the first input (and the second, for
// same-edge DDR) with reset > sr > rev > enable priority.
// Assumes all controls are synchronous to clk.
module dpo_rise_stage #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sr,
    input  logic         rev,
    input  logic         ce,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic [W-1:0] hold_a,
    output logic [W-1:0] hold_b
);
    // Capture both inputs on the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_a <= '0;
            hold_b <= '0;
        end else if (sr) begin
            hold_a <= '0;
            hold_b <= '0;
        end else if (rev) begin
            hold_a <= '1;
            hold_b <= '1;
        end else if (ce) begin
            hold_a <= in_a;
            hold_b <= in_b;
        end
    end
endmodule

// File: rtl/dpo_fall_stage.sv
// Falling-edge stage: clocked by the inverted clock, it stores the
// low-phase DDR value, taken from the raw second input (opposite-edge)
// or from the rising-edge copy of it (same-edge).
// Assumes the alignment select is static.
module dpo_fall_stage #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sr,
    input  logic         rev,
    input  logic         ce,
    input  logic         same_edge,
    input  logic [W-1:0] raw_b,
    input  logic [W-1:0] held_b,
    output logic [W-1:0] low_q
);
    logic [W-1:0] src;

    // Pick the low-phase source for the selected alignment.
    always_comb src = same_edge ? held_b : raw_b;

    // Capture the low-phase value on the falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n)    low_q <= '0;
        else if (sr)   low_q <= '0;
        else if (rev)  low_q <= '1;
        else if (ce)   low_q <= src;
    end
endmodule

// File: rtl/dpo_latch_stage.sv
// Level-sensitive latch: transparent while clk is high, holding while
// clk is low. Controls take effect only in the transparent phase.
module dpo_latch_stage #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sr,
    input  logic         rev,
    input  logic         ce,
    input  logic [W-1:0] in_a,
    output logic [W-1:0] lat_q
);
    // Follow the input during the high phase, hold otherwise.
    always_latch begin
        if (clk) begin
            if (!rst_n)    lat_q = '0;
            else if (sr)   lat_q = '0;
            else if (rev)  lat_q = '1;
            else if (ce)   lat_q = in_a;
        end
    end
endmodule

// File: rtl/dpo_path.sv
// One output path: the storage stages plus the mode multiplexer. In
// DDR mode the clock level selects the high-phase or low-phase value.
// Assumes the mode is static while in use.
module dpo_path
    import dpo_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sr,
    input  logic         rev,
    input  logic [1:0]   mode,
    input  logic         same_edge,
    input  logic         ce,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic [W-1:0] out_q
);
    logic [W-1:0] rise_a;
    logic [W-1:0] rise_b;
    logic [W-1:0] fall_q;
    logic [W-1:0] lat_q;
    path_mode_e   mode_e;

    dpo_rise_stage #(.W(W)) u_rise (
        .clk(clk), .rst_n(rst_n), .sr(sr), .rev(rev), .ce(ce),
        .in_a(in_a), .in_b(in_b), .hold_a(rise_a), .hold_b(rise_b)
    );

    dpo_fall_stage #(.W(W)) u_fall (
        .clk(clk), .rst_n(rst_n), .sr(sr), .rev(rev), .ce(ce),
        .same_edge(same_edge), .raw_b(in_b), .held_b(rise_b),
        .low_q(fall_q)
    );

    dpo_latch_stage #(.W(W)) u_lat (
        .clk(clk), .rst_n(rst_n), .sr(sr), .rev(rev), .ce(ce),
        .in_a(in_a), .lat_q(lat_q)
    );

    // Decode the mode strap.
    always_comb mode_e = path_mode_e'(mode);

    // Choose the output source for the mode; the clock level selects the DDR phase.
    always_comb begin
        case (mode_e)
            MODE_REG:   out_q = rise_a;
            MODE_DDR:   out_q = clk ? rise_a : fall_q;
            MODE_LATCH: out_q = lat_q;
            default:    out_q = in_a;
        endcase
    end
endmodule

// File: rtl/dual_path_out_cell.sv
// Top: a data path and a tristate path, each an independently moded
// dpo_path, sharing the clock, reset, clear and preset.
// Assumes mode and alignment straps are static while in use.
module dual_path_out_cell #(
    parameter int WIDTH    = 4,
    parameter int TS_WIDTH = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sr,
    input  logic                rev,
    input  logic [1:0]          dat_mode,
    input  logic                dat_same_edge,
    input  logic [WIDTH-1:0]    dat_a,
    input  logic [WIDTH-1:0]    dat_b,
    input  logic                dat_ce,
    input  logic [1:0]          ts_mode,
    input  logic                ts_same_edge,
    input  logic [TS_WIDTH-1:0] ts_a,
    input  logic [TS_WIDTH-1:0] ts_b,
    input  logic                ts_ce,
    output logic [WIDTH-1:0]    dat_q,
    output logic [TS_WIDTH-1:0] ts_q
);
    localparam int NPATH = 2;

    generate
        for (genvar p = 0; p < NPATH; p++) begin : g_path
            if (p == 0) begin : g_dat
                dpo_path #(.W(WIDTH)) u_path (
                    .clk(clk), .rst_n(rst_n), .sr(sr), .rev(rev),
                    .mode(dat_mode), .same_edge(dat_same_edge), .ce(dat_ce),
                    .in_a(dat_a), .in_b(dat_b), .out_q(dat_q)
                );
            end else begin : g_ts
                dpo_path #(.W(TS_WIDTH)) u_path (
                    .clk(clk), .rst_n(rst_n), .sr(sr), .rev(rev),
                    .mode(ts_mode), .same_edge(ts_same_edge), .ce(ts_ce),
                    .in_a(ts_a), .in_b(ts_b), .out_q(ts_q)
                );
            end
        end
    endgenerate
endmodule

// File: rtl/dpo_chk.sv
// Checker for dual_path_out_cell: port-level properties on register-mode
// capture, clear/preset priority, enable hold and bypass. Bound below.
module dpo_chk #(
    parameter int WIDTH    = 4,
    parameter int TS_WIDTH = 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sr,
    input logic                rev,
    input logic [1:0]          dat_mode,
    input logic                dat_same_edge,
    input logic [WIDTH-1:0]    dat_a,
    input logic [WIDTH-1:0]    dat_b,
    input logic                dat_ce,
    input logic [1:0]          ts_mode,
    input logic                ts_same_edge,
    input logic [TS_WIDTH-1:0] ts_a,
    input logic [TS_WIDTH-1:0] ts_b,
    input logic                ts_ce,
    input logic [WIDTH-1:0]    dat_q,
    input logic [TS_WIDTH-1:0] ts_q
);
    a_r2_reg_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_mode == 2'b00 && dat_ce && !sr && !rev)
        |=> (dat_mode != 2'b00 || dat_q == $past(dat_a)));

    a_r7_sr_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (sr && dat_mode == 2'b00) |=> (dat_mode != 2'b00 || dat_q == '0));

    a_r7_rev_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rev && !sr && dat_mode == 2'b00) |=> (dat_mode != 2'b00 || dat_q == '1));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_mode == 2'b00 && !dat_ce && !sr && !rev)
        |=> (dat_mode != 2'b00 || dat_q == $past(dat_q)));

    a_r3_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_mode == 2'b11) |-> (dat_q == dat_a));

    a_r9_ts_reg_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_mode == 2'b00 && ts_ce && !sr && !rev)
        |=> (ts_mode != 2'b00 || ts_q == $past(ts_a)));

    a_r9_ts_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_mode == 2'b00 && !ts_ce && !sr && !rev)
        |=> (ts_mode != 2'b00 || ts_q == $past(ts_q)));
endmodule

bind dual_path_out_cell dpo_chk #(.WIDTH(WIDTH), .TS_WIDTH(TS_WIDTH)) u_dpo_chk (.*);

// File: tb/test_dual_path_out_cell.sv
// Bench for dual_path_out_cell: a vector table over mode pairs, then
// directed checks for reset, mid-phase changes, clear/preset and enable.
module test_dual_path_out_cell;
    localparam int W = 4;

    logic clk = 1'b0;
    logic rst_n, sr, rev, dat_same_edge, dat_ce, ts_same_edge, ts_ce;
    logic [1:0] dat_mode, ts_mode;
    logic [W-1:0] dat_a, dat_b, dat_q;
    logic [0:0] ts_a, ts_b, ts_q;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    dual_path_out_cell #(.WIDTH(W), .TS_WIDTH(1)) i_dual_path_out_cell (
        .clk(clk), .rst_n(rst_n), .sr(sr), .rev(rev),
        .dat_mode(dat_mode), .dat_same_edge(dat_same_edge),
        .dat_a(dat_a), .dat_b(dat_b), .dat_ce(dat_ce),
        .ts_mode(ts_mode), .ts_same_edge(ts_same_edge),
        .ts_a(ts_a), .ts_b(ts_b), .ts_ce(ts_ce),
        .dat_q(dat_q), .ts_q(ts_q)
    );

    always #4 clk = ~clk;

    typedef struct packed {
        logic [1:0]   dm;
        logic         ds;
        logic [1:0]   tm;
        logic         tse;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         ta;
        logic         tb;
        logic [W-1:0] qh;
        logic [W-1:0] ql;
        logic         th;
        logic         tl;
    } vec_t;

    // Mode pairs: 00 reg, 01 DDR, 10 latch, 11 bypass; align 1 = same-edge.
    localparam vec_t VECS [8] = '{
        '{2'b00, 1'b0, 2'b00, 1'b0, 4'hA, 4'h5, 1'b1, 1'b0, 4'hA, 4'hA, 1'b1, 1'b1},
        '{2'b01, 1'b0, 2'b00, 1'b0, 4'h3, 4'hC, 1'b0, 1'b1, 4'h3, 4'hC, 1'b0, 1'b0},
        '{2'b01, 1'b1, 2'b01, 1'b0, 4'h6, 4'h9, 1'b1, 1'b0, 4'h6, 4'h9, 1'b1, 1'b0},
        '{2'b10, 1'b0, 2'b01, 1'b1, 4'hE, 4'h1, 1'b0, 1'b1, 4'hE, 4'hE, 1'b0, 1'b1},
        '{2'b11, 1'b0, 2'b10, 1'b0, 4'h7, 4'h8, 1'b1, 1'b0, 4'h7, 4'h7, 1'b1, 1'b1},
        '{2'b00, 1'b0, 2'b11, 1'b0, 4'h2, 4'hD, 1'b0, 1'b1, 4'h2, 4'h2, 1'b0, 1'b0},
        '{2'b01, 1'b0, 2'b01, 1'b1, 4'hF, 4'h0, 1'b1, 1'b0, 4'hF, 4'h0, 1'b1, 1'b0},
        '{2'b01, 1'b1, 2'b10, 1'b0, 4'h4, 4'hB, 1'b0, 1'b1, 4'h4, 4'hB, 1'b0, 1'b0}
    };

    function automatic string req_of(input logic [1:0] m, input logic al);
        case (m)
            2'b00:   return "R2";
            2'b01:   return al ? "R6" : "R5";
            2'b10:   return "R4";
            default: return "R3";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic to_high(); @(posedge clk); #2; endtask
    task automatic to_low();  @(negedge clk); #2; endtask

    initial begin
        rst_n = 1'b0; sr = 1'b0; rev = 1'b0;
        dat_mode = 2'b00; dat_same_edge = 1'b0; dat_a = 4'h9; dat_b = 4'h6; dat_ce = 1'b1;
        ts_mode = 2'b00; ts_same_edge = 1'b0; ts_a = 1'b1; ts_b = 1'b1; ts_ce = 1'b1;
        repeat (3) @(posedge clk);
        to_low();
        // R1: reset cleared the register-mode outputs
        chk("R1", "dat_q in reset", dat_q, 4'h0);
        chk("R1", "ts_q in reset", {3'b0, ts_q}, 4'h0);
        #1; rst_n = 1'b1; ts_ce = 1'b0; dat_ce = 1'b0;
        to_high();
        chk("R1", "dat_q after reset, ce low", dat_q, 4'h0);
        to_low(); #1;
        dat_ce = 1'b1; ts_ce = 1'b1;

        // Table walk; the tristate column covers R9 independence.
        for (int i = 0; i < 8; i++) begin
            dat_mode = VECS[i].dm; dat_same_edge = VECS[i].ds;
            ts_mode = VECS[i].tm; ts_same_edge = VECS[i].tse;
            dat_a = VECS[i].a; dat_b = VECS[i].b;
            ts_a = VECS[i].ta; ts_b = VECS[i].tb;
            to_high();
            chk(req_of(VECS[i].dm, VECS[i].ds), $sformatf("vec %0d dat high", i), dat_q, VECS[i].qh);
            chk("R9", $sformatf("vec %0d ts high (%s)", i, req_of(VECS[i].tm, VECS[i].tse)),
                {3'b0, ts_q}, {3'b0, VECS[i].th});
            to_low();
            chk(req_of(VECS[i].dm, VECS[i].ds), $sformatf("vec %0d dat low", i), dat_q, VECS[i].ql);
            chk("R9", $sformatf("vec %0d ts low (%s)", i, req_of(VECS[i].tm, VECS[i].tse)),
                {3'b0, ts_q}, {3'b0, VECS[i].tl});
            #1;
        end

        // R6: same-edge ignores a second-input change after the rising edge
        dat_mode = 2'b01; dat_same_edge = 1'b1; dat_a = 4'h1; dat_b = 4'h2;
        @(posedge clk); #1; dat_b = 4'h7; #1;
        chk("R6", "same-edge high", dat_q, 4'h1);
        to_low();
        chk("R6", "same-edge low keeps edge value", dat_q, 4'h2);
        #1;
        // R5: opposite-edge picks up the change before the falling edge
        dat_same_edge = 1'b0; dat_a = 4'h1; dat_b = 4'h2;
        @(posedge clk); #1; dat_b = 4'h7; #1;
        chk("R5", "opposite-edge high", dat_q, 4'h1);
        to_low();
        chk("R5", "opposite-edge low takes late value", dat_q, 4'h7);
        #1;

        // R4: latch follows in high phase, holds in low phase
        dat_mode = 2'b10; dat_a = 4'h3;
        @(posedge clk); #1; dat_a = 4'h9; #1;
        chk("R4", "latch transparent", dat_q, 4'h9);
        @(negedge clk); #1; dat_a = 4'hA; #1;
        chk("R4", "latch holds in low phase", dat_q, 4'h9);
        #1;

        // R3: bypass reflects a low-phase change at once
        dat_mode = 2'b11;
        @(negedge clk); #1; dat_a = 4'h6; #1;
        chk("R3", "bypass in low phase", dat_q, 4'h6);
        #1;

        // R7: sr wins over rev, rev alone sets all ones
        dat_mode = 2'b00; ts_mode = 2'b00; dat_a = 4'hF; ts_a = 1'b1;
        sr = 1'b1; rev = 1'b1;
        to_high();
        chk("R7", "sr over rev dat", dat_q, 4'h0);
        chk("R7", "sr over rev ts", {3'b0, ts_q}, 4'h0);
        to_low(); #1;
        sr = 1'b0; dat_a = 4'h0; ts_a = 1'b0;
        to_high();
        chk("R7", "rev sets dat", dat_q, 4'hF);
        chk("R7", "rev sets ts", {3'b0, ts_q}, 4'h1);
        to_low(); #1;
        rev = 1'b0;

        // R8 and R9: data enable low holds, tristate still captures
        dat_ce = 1'b0; dat_a = 4'h5; ts_a = 1'b0;
        to_high();
        chk("R8", "dat holds with ce low", dat_q, 4'hF);
        chk("R9", "ts captures while dat held", {3'b0, ts_q}, 4'h0);
        to_low(); #1;
        // R8: DDR low phase also holds with ce low
        dat_ce = 1'b1; dat_mode = 2'b01; dat_same_edge = 1'b0; dat_a = 4'h8; dat_b = 4'h4;
        to_high(); to_low(); #1;
        dat_ce = 1'b0; ts_ce = 1'b0; dat_a = 4'h2; dat_b = 4'hD; ts_a = 1'b1;
        to_high();
        chk("R8", "DDR high holds", dat_q, 4'h8);
        chk("R8", "ts holds with ce low", {3'b0, ts_q}, 4'h0);
        to_low();
        chk("R8", "DDR low holds", dat_q, 4'h4);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule